// File: doc/BRIEF.md
# Selectable periodic interrupt generator

This block produces an active-low interrupt request for a real-time clock from a 3-bit mode selector. It can hold the request idle or asserted. It can pass a 2 Hz or 1 Hz square wave from the crystal divider straight to the request. It can also latch a level interrupt on a second, minute, hour or month rollover of the calendar counter. In the latched case a status flag lets the host poll the event, and the host clears it by writing 0. The final request also merges the alarm sources, so that one request line serves all interrupt causes.

The block also produces the one-cycle strobe that advances the seconds counter. In the square-wave modes this strobe follows the falling edge of the 1 Hz tap after a parameterised number of 32.768 kHz ticks; the default is 3 ticks, which is about 92 µs. In every other mode the strobe follows the tap edge at once, so a level-mode firing lines up with the seconds increment. All logic runs on one fast clock with a synchronous active-high reset. Every output is registered.

Top module: `periodic_irq_gen`

## Requirements
- R1: Under reset and in mode 000 with no alarm, irq_n_o is 1, flag_o is 0 and sec_adv_o is 0; mode 000 with no alarm keeps irq_n_o at 1.
- R2: Mode 001 drives irq_n_o to 0 on the clock edge after the mode is applied, for as long as the mode is held.
- R3: Mode 010 makes irq_n_o equal to tap_2hz_i, and mode 011 makes it equal to tap_1hz_i, with one register of delay.
- R4: In modes 100, 101, 110 and 111 a strobe on roll_i bit 0 (second), bit 1 (minute), bit 2 (hour) or bit 3 (month) sets flag_o to 1 and irq_n_o to 0 at the same edge. Only the bit that matches the mode has this effect.
- R5: A latched level assertion holds flag_o at 1 and irq_n_o at 0 until a cycle with clr_we_i=1 and clr_bit_i=0. Both outputs release at that edge.
- R6: A write with clr_we_i=1 and clr_bit_i=1 leaves flag_o and irq_n_o unchanged.
- R7: Any change of mode_i clears a pending level assertion at the edge where the new value is first sampled.
- R8: Any bit of alarm_i at 1 drives irq_n_o to 0 on the next edge, whatever the mode.
- R9: In modes 010 and 011 a falling edge of tap_1hz_i yields a single-cycle sec_adv_o. The strobe appears on the edge that samples the DELAY_TICKS-th tick_32k_i pulse after the fall.
- R10: In modes other than 010 and 011, sec_adv_o pulses for one cycle on the edge that samples the fall of tap_1hz_i. In modes 010 and 011, roll_i has no effect on flag_o.
- R11: When a matching rollover strobe and a clear write fall in the same cycle, the firing wins and flag_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_32k_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| tap_2hz_i | input | 1 | 2 Hz divider tap, 50% duty |
| tap_1hz_i | input | 1 | 1 Hz divider tap, 50% duty |
| roll_i | input | 4 | Rollover strobes: bit0 second, bit1 minute, bit2 hour, bit3 month |
| mode_i | input | 3 | Interrupt mode selector |
| clr_we_i | input | 1 | Host write strobe to the status flag |
| clr_bit_i | input | 1 | Data written to the flag; only 0 has effect |
| alarm_i | input | ALARM_N | Alarm requests, active high |
| irq_n_o | output | 1 | Merged interrupt request, active low |
| flag_o | output | 1 | Latched level-interrupt status |
| sec_adv_o | output | 1 | Seconds-advance strobe to the calendar counter |

## Verification
On every cycle, the assertions check the constant modes, the alarm override and the flag's hold-until-clear behaviour. They also check that an asserted flag always pairs with a low request and that the seconds strobe never lasts two cycles. Only the bench scenarios show the following: the delay of the seconds strobe counted in 32 kHz ticks, the one-to-one mapping of mode to rollover bit, the clearing on a mode change, and the firing winning over a simultaneous clear.

// File: rtl/pi_pkg.sv
package pi_pkg;
  typedef enum logic [2:0] {
    PI_OFF     = 3'b000,
    PI_LOW     = 3'b001,
    PI_WAVE2   = 3'b010,
    PI_WAVE1   = 3'b011,
    PI_LVL_SEC = 3'b100,
    PI_LVL_MIN = 3'b101,
    PI_LVL_HR  = 3'b110,
    PI_LVL_MON = 3'b111
  } pi_mode_e;

  localparam int PI_ROLL_N = 4;

  function automatic logic pi_is_wave(input logic [2:0] m);
    return (m == PI_WAVE2) || (m == PI_WAVE1);
  endfunction

  function automatic logic pi_is_level(input logic [2:0] m);
    return m[2];
  endfunction
endpackage

// File: rtl/pi_sec_step.sv
module pi_sec_step #(
  parameter int DELAY_TICKS = 3,
  localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic tap_i,
  input  logic delayed_i,
  output logic step_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic             tap_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;

  assign fall = tap_q & ~tap_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      step_o <= 1'b0;
    end else begin
      tap_q  <= tap_i;
      step_o <= 1'b0;
      if (fall) begin
        if (delayed_i) begin
          pend_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          step_o <= 1'b1;
        end
      end else if (pend_q && tick_i) begin
        if (cnt_q == LAST) begin
          step_o <= 1'b1;
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pi_level_latch.sv
module pi_level_latch (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic drop_i,
  input  logic clear_i,
  output logic set_next_o,
  output logic set_q_o
);
  always_comb begin
    if (drop_i)       set_next_o = 1'b0;
    else if (fire_i)  set_next_o = 1'b1;
    else if (clear_i) set_next_o = 1'b0;
    else              set_next_o = set_q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) set_q_o <= 1'b0;
    else     set_q_o <= set_next_o;
  end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pi_pkg::*;
#(
  parameter int DELAY_TICKS = 3,
  parameter int ALARM_N     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_32k_i,
  input  logic               tap_2hz_i,
  input  logic               tap_1hz_i,
  input  logic [3:0]         roll_i,
  input  logic [2:0]         mode_i,
  input  logic               clr_we_i,
  input  logic               clr_bit_i,
  input  logic [ALARM_N-1:0] alarm_i,
  output logic               irq_n_o,
  output logic               flag_o,
  output logic               sec_adv_o
);
  logic [2:0] mode_q;
  logic       mode_chg;
  logic       fire;
  logic       host_clr;
  logic       lat_next;
  logic       wave_low;
  logic [PI_ROLL_N-1:0] roll_sel;

  assign mode_chg = (mode_i != mode_q);
  assign host_clr = clr_we_i & ~clr_bit_i;

  for (genvar g = 0; g < PI_ROLL_N; g++) begin : g_roll
    assign roll_sel[g] = roll_i[g] & (mode_i[1:0] == 2'(g));
  end

  assign fire = pi_is_level(mode_i) & (|roll_sel);

  always_comb begin
    case (mode_i)
      PI_LOW:   wave_low = 1'b1;
      PI_WAVE2: wave_low = ~tap_2hz_i;
      PI_WAVE1: wave_low = ~tap_1hz_i;
      default:  wave_low = 1'b0;
    endcase
  end

  pi_level_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .fire_i    (fire),
    .drop_i    (mode_chg),
    .clear_i   (host_clr),
    .set_next_o(lat_next),
    .set_q_o   (flag_o)
  );

  pi_sec_step #(.DELAY_TICKS(DELAY_TICKS)) u_step (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_32k_i),
    .tap_i    (tap_1hz_i),
    .delayed_i(pi_is_wave(mode_i)),
    .step_o   (sec_adv_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PI_OFF;
      irq_n_o <= 1'b1;
    end else begin
      mode_q  <= mode_i;
      irq_n_o <= ~(wave_low | lat_next | (|alarm_i));
    end
  end
endmodule

// File: rtl/pi_checker.sv
module pi_checker #(
  parameter int ALARM_N = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         mode_i,
  input logic [ALARM_N-1:0] alarm_i,
  input logic               clr_we_i,
  input logic               clr_bit_i,
  input logic               irq_n_o,
  input logic               flag_o,
  input logic               sec_adv_o
);
  a_r1_off_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b000 && alarm_i == '0) |=> irq_n_o);

  a_r2_const_low: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b001) |=> !irq_n_o);

  a_r5_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !(clr_we_i && !clr_bit_i) && $stable(mode_i)) |=> flag_o);

  a_r5_flag_means_low: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> !irq_n_o);

  a_r8_alarm_merge: assert property (@(posedge clk) disable iff (rst)
    (alarm_i != '0) |=> !irq_n_o);

  a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
    sec_adv_o |=> !sec_adv_o);
endmodule

bind periodic_irq_gen pi_checker #(.ALARM_N(ALARM_N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_i   (mode_i),
  .alarm_i  (alarm_i),
  .clr_we_i (clr_we_i),
  .clr_bit_i(clr_bit_i),
  .irq_n_o  (irq_n_o),
  .flag_o   (flag_o),
  .sec_adv_o(sec_adv_o)
);

// File: tb/periodic_irq_gen_test.sv
module periodic_irq_gen_test;
  localparam int ALARM_N = 2;

  typedef struct {
    logic  irq_n;
    logic  flag;
    logic  adv;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, tap2 = 1'b1, tap1 = 1'b1;
  logic [3:0] roll = '0;
  logic [2:0] mode = '0;
  logic clr_we = 1'b0, clr_bit = 1'b0;
  logic [ALARM_N-1:0] alarm = '0;
  logic irq_n, flag, adv;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  periodic_irq_gen #(.DELAY_TICKS(3), .ALARM_N(ALARM_N)) uut (
    .clk(clk), .rst(rst), .tick_32k_i(tick), .tap_2hz_i(tap2), .tap_1hz_i(tap1),
    .roll_i(roll), .mode_i(mode), .clr_we_i(clr_we), .clr_bit_i(clr_bit),
    .alarm_i(alarm), .irq_n_o(irq_n), .flag_o(flag), .sec_adv_o(adv)
  );

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic ex(input logic i, input logic f, input logic a, input string t);
    exp_t e;
    e.irq_n = i; e.flag = f; e.adv = a; e.tag = t;
    q.push_back(e);
  endtask

  // monitor: pops one expected item per clock edge, samples after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (irq_n !== e.irq_n || flag !== e.flag || adv !== e.adv) begin
          n_fail++;
          $display("FAIL %s: got irq_n=%b flag=%b adv=%b, expected irq_n=%b flag=%b adv=%b",
                   e.tag, irq_n, flag, adv, e.irq_n, e.flag, e.adv);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    nx(); rst = 1'b1; ex(1, 0, 0, "R1 in reset");
    nx(); rst = 1'b0; ex(1, 0, 0, "R1 after reset");
    nx(); mode = 3'b001; ex(0, 0, 0, "R2 forced low");
    nx();                ex(0, 0, 0, "R2 held low");
    nx(); mode = 3'b010; ex(1, 0, 0, "R3 2Hz high");
    nx(); tap2 = 1'b0;   ex(0, 0, 0, "R3 2Hz low");
    nx(); tap2 = 1'b1;   ex(1, 0, 0, "R3 2Hz high again");
    nx(); mode = 3'b011; ex(1, 0, 0, "R3 1Hz high");
    nx(); tap1 = 1'b0;   ex(0, 0, 0, "R9 no step on the fall itself");
    nx(); tick = 1'b1;   ex(0, 0, 0, "R9 after tick 1");
    nx(); tick = 1'b0;   ex(0, 0, 0, "R9 idle");
    nx(); tick = 1'b1;   ex(0, 0, 0, "R9 after tick 2");
    nx();                ex(0, 0, 1, "R9 step on tick 3");
    nx(); tick = 1'b0;   ex(0, 0, 0, "R9 step lasts one cycle");
    nx(); roll = 4'b0001; ex(0, 0, 0, "R10 wave mode ignores rollover");
    nx(); roll = '0; tap1 = 1'b1; mode = 3'b100; ex(1, 0, 0, "R7 enter second level mode");
    nx(); roll = 4'b0001; ex(0, 1, 0, "R4 second firing");
    nx(); roll = '0;      ex(0, 1, 0, "R5 latched");
    nx(); clr_we = 1'b1; clr_bit = 1'b1; ex(0, 1, 0, "R6 write 1 ignored");
    nx(); clr_bit = 1'b0; ex(1, 0, 0, "R5 write 0 clears");
    nx(); clr_we = 1'b0; mode = 3'b101; ex(1, 0, 0, "R4 minute mode idle");
    nx(); roll = 4'b0001; ex(1, 0, 0, "R4 second strobe ignored in minute mode");
    nx(); roll = 4'b0010; ex(0, 1, 0, "R4 minute firing");
    nx(); roll = '0; mode = 3'b110; ex(1, 0, 0, "R7 mode change clears");
    nx(); roll = 4'b0100; clr_we = 1'b1; clr_bit = 1'b0; ex(0, 1, 0, "R11 firing beats clear");
    nx(); roll = '0;      ex(1, 0, 0, "R5 clear after hour firing");
    nx(); clr_we = 1'b0; mode = 3'b111; ex(1, 0, 0, "R4 month mode idle");
    nx(); roll = 4'b1000; ex(0, 1, 0, "R4 month firing");
    nx(); roll = '0; mode = 3'b100; tap1 = 1'b0; ex(1, 0, 1, "R10 immediate step and R7 clear");
    nx(); tap1 = 1'b1; mode = 3'b000; ex(1, 0, 0, "R1 off mode");
    nx(); alarm = 2'b10; ex(0, 0, 0, "R8 alarm pulls low");
    nx(); alarm = '0;    ex(1, 0, 0, "R8 alarm released");
    nx(); nx(); nx();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule